// File: doc/BRIEF.md
# PLL Divider-Preset Mode Controller

This block sits in front of a bang-bang PLL core and takes the loop from reset to closed-loop tracking. It has two external controls: a 5-bit feedback-divider request and an enable. When the enable rises, the block captures the divider request. It then looks up a characterized preset for that ratio: an oscillator coarse band, an 8-bit fine-code seed, an integral gain and a proportional gain. It also forms a 10-bit loop-filter seed from the fine code.

For a supported ratio, the block pulses the loop-filter clear for one cycle so the filter loads the seed. On the next cycle it raises the tracking enable and holds it while the enable stays high.

An unsupported ratio still reaches the divider bus, so it can be observed there. The preset valid flag stays low for that ratio, and the controller parks in an invalid state that never enables tracking. Dropping the enable returns the controller to idle. A 3-bit status code reports the sequencer state.

Top module: `divpreset_ctrl`

## Requirements
- R1: After reset, the status is idle (code 0), tracking and clear are low, the divider bus reads 0 and the valid flag is low.
- R2: The divider request is captured only on a rising edge of the enable, sampled at the clock edge where the enable is first seen high. Later changes to the request leave the divider bus and the presets unchanged until the enable has gone low and risen again.
- R3: The supported ratios and their presets are as follows (ratio → coarse band, fine seed):
  - 20 → 1, 121
  - 16 → 2, 76
  - 12 → 4, 90
  - 10 → 6, 234
  - 4 → 20, 93

  Every supported ratio uses integral gain 16 and proportional gain 4, and its valid flag is 1.
- R4: The loop-filter seed equals the fine seed multiplied by 4 (fine seed in bits 9:2, bits 1:0 zero).
- R5: For any other ratio, the divider bus still shows the captured value. The valid flag is 0, and the coarse band, fine seed, gains and filter seed all read 0. The status moves to invalid (code 4) and tracking never asserts.
- R6: For a supported ratio, the sequence starts at the clock edge that captures the request and runs as follows:
  - After that edge, the status shows load (code 1) for exactly one cycle.
  - It then shows clear (code 2) for exactly one cycle, with the clear output high.
  - It then shows track (code 3), with tracking high until the enable falls.
- R7: While the enable is low at a clock edge, the status becomes idle and tracking is low after that edge, from any state.
- R8: The clear output is high only in the clear state, never in two consecutive cycles, and never together with tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Divider-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pll_en | input | 1 | PLL enable; its rising edge starts a sequence |
| div_req | input | 5 | Requested feedback-divider ratio |
| div_out | output | 5 | Captured ratio driven to the divider |
| cfg_ok | output | 1 | Captured ratio has a preset |
| coarse_band | output | 5 | Oscillator coarse band preset |
| fine_seed | output | 8 | Oscillator fine-code seed |
| gain_int | output | 5 | Integral gain preset |
| gain_prop | output | 3 | Proportional gain preset |
| filt_seed | output | 10 | Loop-filter seed value |
| filt_clear | output | 1 | One-cycle loop-filter clear/load pulse |
| track_en | output | 1 | Closed-loop tracking enable |
| state_code | output | 3 | Sequencer status (0 idle, 1 load, 2 clear, 3 track, 4 invalid) |

## Verification
The assertions check the timing rules on every cycle:
- a single clear pulse that is followed by tracking;
- tracking only while the valid flag is high;
- a return to idle one edge after the enable drops;
- a divider bus that holds steady outside idle;
- the fixed gains and the low seed bits whenever a preset is valid.

Only the bench's sweep over all 32 request values shows three things: that each ratio maps to its own band and seed, that every other value blanks the presets and parks in the invalid state, and that a request changed mid-sequence has no effect.

// File: rtl/divpreset_pkg.sv
package divpreset_pkg;

  localparam int DIV_W      = 5;
  localparam int BAND_W     = 5;
  localparam int FINE_W     = 8;
  localparam int SEED_SHIFT = 2;
  localparam int SEED_W     = FINE_W + SEED_SHIFT;
  localparam int KI_W       = 5;
  localparam int KP_W       = 3;
  localparam int ST_W       = 3;

  localparam logic [KI_W-1:0] KI_PRESET = KI_W'(16);
  localparam logic [KP_W-1:0] KP_PRESET = KP_W'(4);

  typedef enum logic [ST_W-1:0] {
    ST_IDLE  = 3'd0,
    ST_LOAD  = 3'd1,
    ST_CLEAR = 3'd2,
    ST_TRACK = 3'd3,
    ST_BAD   = 3'd4
  } ctl_state_e;

  typedef struct packed {
    logic              ok;
    logic [BAND_W-1:0] band;
    logic [FINE_W-1:0] fine;
    logic [KI_W-1:0]   ki;
    logic [KP_W-1:0]   kp;
  } preset_t;

  // Characterized preset for one divider ratio; unsupported ratios give all zero.
  function automatic preset_t preset_lookup(input logic [DIV_W-1:0] ratio);
    preset_t p;
    p = '0;
    case (ratio)
      DIV_W'(4):  begin p.ok = 1'b1; p.band = BAND_W'(20); p.fine = FINE_W'(93);  end
      DIV_W'(10): begin p.ok = 1'b1; p.band = BAND_W'(6);  p.fine = FINE_W'(234); end
      DIV_W'(12): begin p.ok = 1'b1; p.band = BAND_W'(4);  p.fine = FINE_W'(90);  end
      DIV_W'(16): begin p.ok = 1'b1; p.band = BAND_W'(2);  p.fine = FINE_W'(76);  end
      DIV_W'(20): begin p.ok = 1'b1; p.band = BAND_W'(1);  p.fine = FINE_W'(121); end
      default:    p = '0;
    endcase
    if (p.ok) begin
      p.ki = KI_PRESET;
      p.kp = KP_PRESET;
    end
    return p;
  endfunction

  // Loop-filter seed: fine code scaled into the wider filter word.
  function automatic logic [SEED_W-1:0] seed_from_fine(input logic [FINE_W-1:0] fine);
    return {fine, {SEED_SHIFT{1'b0}}};
  endfunction

endpackage

// File: rtl/dp_edge_latch.sv
module dp_edge_latch
  import divpreset_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_in,
  input  logic [DIV_W-1:0] req_in,
  output logic             en_rise,
  output logic [DIV_W-1:0] ratio_q
);

  logic en_prev;

  assign en_rise = en_in & ~en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
      ratio_q <= '0;
    end else begin
      en_prev <= en_in;
      if (en_rise) ratio_q <= req_in;
    end
  end

endmodule

// File: rtl/dp_preset_rom.sv
module dp_preset_rom
  import divpreset_pkg::*;
(
  input  logic [DIV_W-1:0]  ratio,
  output logic              ok,
  output logic [BAND_W-1:0] band,
  output logic [FINE_W-1:0] fine,
  output logic [KI_W-1:0]   ki,
  output logic [KP_W-1:0]   kp,
  output logic [SEED_W-1:0] seed
);

  preset_t entry;

  always_comb begin
    entry = preset_lookup(ratio);
    ok    = entry.ok;
    band  = entry.band;
    fine  = entry.fine;
    ki    = entry.ki;
    kp    = entry.kp;
    seed  = entry.ok ? seed_from_fine(entry.fine) : '0;
  end

endmodule

// File: rtl/dp_seq_fsm.sv
module dp_seq_fsm
  import divpreset_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_in,
  input  logic            en_rise,
  input  logic            cfg_ok,
  output logic            clear_pulse,
  output logic            track_on,
  output logic [ST_W-1:0] st_code
);

  ctl_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en_in) begin
      st_d = ST_IDLE;
    end else begin
      case (st_q)
        ST_IDLE:  st_d = en_rise ? ST_LOAD : ST_IDLE;
        ST_LOAD:  st_d = cfg_ok ? ST_CLEAR : ST_BAD;
        ST_CLEAR: st_d = ST_TRACK;
        ST_TRACK: st_d = ST_TRACK;
        ST_BAD:   st_d = ST_BAD;
        default:  st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign clear_pulse = (st_q == ST_CLEAR);
  assign track_on    = (st_q == ST_TRACK);
  assign st_code     = st_q;

endmodule

// File: rtl/divpreset_ctrl.sv
module divpreset_ctrl
  import divpreset_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pll_en,
  input  logic [DIV_W-1:0]  div_req,
  output logic [DIV_W-1:0]  div_out,
  output logic              cfg_ok,
  output logic [BAND_W-1:0] coarse_band,
  output logic [FINE_W-1:0] fine_seed,
  output logic [KI_W-1:0]   gain_int,
  output logic [KP_W-1:0]   gain_prop,
  output logic [SEED_W-1:0] filt_seed,
  output logic              filt_clear,
  output logic              track_en,
  output logic [ST_W-1:0]   state_code
);

  logic             en_rise;
  logic [DIV_W-1:0] ratio_q;

  dp_edge_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_in   (pll_en),
    .req_in  (div_req),
    .en_rise (en_rise),
    .ratio_q (ratio_q)
  );

  dp_preset_rom u_rom (
    .ratio (ratio_q),
    .ok    (cfg_ok),
    .band  (coarse_band),
    .fine  (fine_seed),
    .ki    (gain_int),
    .kp    (gain_prop),
    .seed  (filt_seed)
  );

  dp_seq_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_in       (pll_en),
    .en_rise     (en_rise),
    .cfg_ok      (cfg_ok),
    .clear_pulse (filt_clear),
    .track_on    (track_en),
    .st_code     (state_code)
  );

  assign div_out = ratio_q;

endmodule

// File: rtl/divpreset_ctrl_chk.sv
module divpreset_ctrl_chk
  import divpreset_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pll_en,
  input logic [DIV_W-1:0]  div_out,
  input logic              cfg_ok,
  input logic [KI_W-1:0]   gain_int,
  input logic [KP_W-1:0]   gain_prop,
  input logic [SEED_W-1:0] filt_seed,
  input logic              filt_clear,
  input logic              track_en,
  input logic [ST_W-1:0]   state_code
);

  // R8
  clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clear |=> !filt_clear);

  // R6
  clear_then_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_clear && pll_en) |=> track_en);

  // R8
  clear_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_clear |-> ($past(state_code) == 3'd1) && !track_en);

  // R5
  track_needs_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    track_en |-> cfg_ok);

  // R7
  disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pll_en |=> (state_code == 3'd0) && !track_en);

  // R2
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code != 3'd0) |=> $stable(div_out));

  // R3
  gain_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |-> (gain_int == KI_W'(16)) && (gain_prop == KP_W'(4)));

  // R4
  seed_low_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    filt_seed[SEED_SHIFT-1:0] == '0);

endmodule

bind divpreset_ctrl divpreset_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pll_en     (pll_en),
  .div_out    (div_out),
  .cfg_ok     (cfg_ok),
  .gain_int   (gain_int),
  .gain_prop  (gain_prop),
  .filt_seed  (filt_seed),
  .filt_clear (filt_clear),
  .track_en   (track_en),
  .state_code (state_code)
);

// File: tb/sim_divpreset_ctrl.sv
`timescale 1ns/1ps
module sim_divpreset_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pll_en = 1'b0;
  logic [4:0] div_req = '0;
  logic [4:0] div_out;
  logic       cfg_ok;
  logic [4:0] coarse_band;
  logic [7:0] fine_seed;
  logic [4:0] gain_int;
  logic [2:0] gain_prop;
  logic [9:0] filt_seed;
  logic       filt_clear;
  logic       track_en;
  logic [2:0] state_code;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  divpreset_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .pll_en(pll_en), .div_req(div_req),
    .div_out(div_out), .cfg_ok(cfg_ok), .coarse_band(coarse_band),
    .fine_seed(fine_seed), .gain_int(gain_int), .gain_prop(gain_prop),
    .filt_seed(filt_seed), .filt_clear(filt_clear), .track_en(track_en),
    .state_code(state_code)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_band(input int r);
    case (r)
      4: return 20; 10: return 6; 12: return 4; 16: return 2; 20: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic int exp_fine(input int r);
    case (r)
      4: return 93; 10: return 234; 12: return 90; 16: return 76; 20: return 121;
      default: return 0;
    endcase
  endfunction

  task automatic check_presets(input int r);
    bit good;
    good = (exp_band(r) != 0);
    chk("R3", "cfg_ok", int'(cfg_ok), good ? 1 : 0);
    chk(good ? "R3" : "R5", "band", int'(coarse_band), exp_band(r));
    chk(good ? "R3" : "R5", "fine", int'(fine_seed), exp_fine(r));
    chk(good ? "R3" : "R5", "ki", int'(gain_int), good ? 16 : 0);
    chk(good ? "R3" : "R5", "kp", int'(gain_prop), good ? 4 : 0);
    chk("R4", "filt_seed", int'(filt_seed), exp_fine(r) * 4);
  endtask

  // One full enable cycle for ratio r, with a request change mid-sequence.
  task automatic run_ratio(input int r);
    bit good;
    good = (exp_band(r) != 0);
    @(negedge clk);
    pll_en  = 1'b1;
    div_req = 5'(r);
    @(negedge clk);
    chk("R6", "load state", int'(state_code), 1);
    chk("R2", "div_out", int'(div_out), r);
    chk("R8", "clear in load", int'(filt_clear), 0);
    div_req = 5'(r) ^ 5'h1f;
    @(negedge clk);
    chk(good ? "R6" : "R5", "second state", int'(state_code), good ? 2 : 4);
    chk("R8", "clear", int'(filt_clear), good ? 1 : 0);
    chk("R6", "track early", int'(track_en), 0);
    check_presets(r);
    @(negedge clk);
    chk(good ? "R6" : "R5", "third state", int'(state_code), good ? 3 : 4);
    chk(good ? "R6" : "R5", "track", int'(track_en), good ? 1 : 0);
    chk("R8", "clear gone", int'(filt_clear), 0);
    chk("R2", "div_out held", int'(div_out), r);
    check_presets(r);
    repeat (3) @(negedge clk);
    chk(good ? "R6" : "R5", "track kept", int'(track_en), good ? 1 : 0);
    pll_en = 1'b0;
    @(negedge clk);
    chk("R7", "idle after disable", int'(state_code), 0);
    chk("R7", "track off", int'(track_en), 0);
    chk("R2", "div_out after disable", int'(div_out), r);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "state", int'(state_code), 0);
    chk("R1", "track", int'(track_en), 0);
    chk("R1", "clear", int'(filt_clear), 0);
    chk("R1", "div_out", int'(div_out), 0);
    chk("R1", "cfg_ok", int'(cfg_ok), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle after release", int'(state_code), 0);

    for (int r = 0; r < 32; r++) run_ratio(r);
    for (int r = 31; r >= 0; r--) if (exp_band(r) != 0) run_ratio(r);

    // Enable held high: a new request without a rising edge is ignored (R2).
    @(negedge clk);
    pll_en = 1'b1; div_req = 5'd16;
    repeat (3) @(negedge clk);
    chk("R6", "track on 16", int'(state_code), 3);
    div_req = 5'd7;
    repeat (4) @(negedge clk);
    chk("R2", "no relatch", int'(div_out), 16);
    chk("R2", "band held", int'(coarse_band), 2);
    chk("R2", "still tracking", int'(track_en), 1);

    // Disable from the load state (R7).
    pll_en = 1'b0;
    @(negedge clk);
    pll_en = 1'b1; div_req = 5'd10;
    @(negedge clk);
    chk("R6", "load 10", int'(state_code), 1);
    pll_en = 1'b0;
    @(negedge clk);
    chk("R7", "idle from load", int'(state_code), 0);
    chk("R7", "no clear after abort", int'(filt_clear), 0);

    // Disable from the invalid state, then a valid retry (R5, R7).
    pll_en = 1'b1; div_req = 5'd5;
    repeat (2) @(negedge clk);
    chk("R5", "invalid parked", int'(state_code), 4);
    pll_en = 1'b0;
    @(negedge clk);
    chk("R7", "idle from invalid", int'(state_code), 0);
    run_ratio(4);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule